// File: doc/BRIEF.md
# Escaped Message Frame Transmitter

This block turns a message that already sits in a byte buffer into a framed byte stream for a character link. The buffer layout is: position 0 holds a length, position 1 a network-function byte, position 2 a sequence number, and the payload follows. On a start pulse the block walks the buffer through a random-access read port. It leaves out the length, sends the sequence number ahead of the network-function byte, and escapes any byte that would collide with a framing code. It then appends a checksum and closes the frame with an end-of-message code.

The framing codes are 0xA0 (end of message), 0xA1 (end of command) and 0xAA (escape). When the link reports that it has come up, the block also sends a short command frame that announces protocol version 1. Bytes leave through a valid/ready handshake. A busy flag tells the producer when a new start will be accepted.

Top module: `esc_frame_tx`

## Requirements
- R1: For a start with length L >= 3, the body sent is buffer positions 1 to L-1; position 0 (the length byte) never appears in the stream.
- R2: Buffer positions 2 and 1 go out in that order (sequence first, then network function), followed by positions 3 to L-1 in ascending order.
- R3: A body or checksum byte equal to 0xA0, 0xA1 or 0xAA is sent as 0xAA followed by the byte OR 0x10. Every other byte is sent unchanged.
- R4: After the body comes one checksum byte equal to 0 minus the 8-bit sum of the unescaped body bytes. It is escaped under R3 like a body byte.
- R5: Every message frame ends with a single 0xA0 that is never escaped.
- R6: A link-up pulse makes the block send 0xFF, 0x01 and then an unescaped 0xA1.
- R7: A byte moves on a rising clock edge where valid and ready are both high. While valid is high and ready is low, valid stays high and the data stays unchanged.
- R8: busy goes high in the cycle after an accepted start and stays high until the terminator has been accepted. A start that arrives while busy is high is ignored.
- R9: A start with a length below 3 reads no buffer bytes and sends only the checksum 0x00 followed by 0xA0.
- R10: A link-up pulse during a frame is held, and its announce frame follows that frame's terminator with busy held high in between. If link-up and start arrive in the same idle cycle, only the announce is sent and the start is dropped.
- R11: During and right after reset, valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a message frame |
| start_len_i | input | LEN_W (7) | Number of buffered bytes, length byte included |
| link_up_i | input | 1 | One-cycle pulse that asks for the version announce |
| busy_o | output | 1 | A frame is in progress; a start is ignored |
| buf_addr_o | output | ADDR_W (6) | Read address into the message buffer |
| buf_data_i | input | 8 | Buffer byte at buf_addr_o, same cycle |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | The sink takes the byte on this edge |

## Verification
A table of messages drives the main path. The messages are plain bytes, framing codes placed in the swapped header positions and in the payload, and bodies whose checksum itself lands on 0xA0 or 0xAA. Together they separate a missing swap, a missing or misplaced escape, a checksum taken over escaped bytes instead of raw ones, and an escaped terminator. Each message runs with the sink always ready, ready on alternate cycles and ready one cycle in three, which exposes any byte that is dropped or repeated under backpressure. Directed cases cover short lengths, a start while busy, a link-up alone, a link-up during a frame, and a link-up that arrives together with a start.

// File: rtl/esc_tx_pkg.sv
// esc_tx_pkg: framing codes, sequencer states and the reserved-code test
// shared by the escaped frame transmitter modules.
package esc_tx_pkg;

    localparam logic [7:0] CODE_EOM = 8'hA0;   // closes a message frame
    localparam logic [7:0] CODE_EOC = 8'hA1;   // closes a command frame
    localparam logic [7:0] CODE_ESC = 8'hAA;   // escape prefix
    localparam logic [7:0] ESC_FLIP = 8'h10;   // bit set on an escaped byte
    localparam logic [7:0] VER_CMD  = 8'hFF;   // version announce command
    localparam logic [7:0] VER_NUM  = 8'h01;   // protocol version

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_CSUM,
        ST_TERM,
        ST_VCMD,
        ST_VNUM,
        ST_VTERM
    } seq_state_e;

    // True when a byte collides with one of the three framing codes.
    function automatic logic is_reserved(input logic [7:0] b);
        return (b == CODE_EOM) || (b == CODE_EOC) || (b == CODE_ESC);
    endfunction

endpackage

// File: rtl/esc_tx_csum.sv
// esc_tx_csum: running 8-bit sum of the body bytes and its two's complement.
// Assumes clr_i and add_i are not both high in the same cycle; clear wins.
module esc_tx_csum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         add_i,
    input  logic [W-1:0] byte_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] neg_o
);

    logic [W-1:0] sum_q;

    // Accumulate accepted body bytes; restart on a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     sum_q <= '0;
        else if (clr_i) sum_q <= '0;
        else if (add_i) sum_q <= sum_q + byte_i;
    end

    // Checksum byte: the value that brings the total to zero.
    always_comb begin
        sum_o = sum_q;
        neg_o = '0 - sum_q;
    end

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_o == '0 && neg_o == '0));

endmodule

// File: rtl/esc_tx_seq.sv
// esc_tx_seq: chooses the logical symbol to send next. A message frame is
// the reordered body, the checksum and the end-of-message code; an announce
// frame is command, version and end-of-command. Each symbol carries a raw
// flag that keeps the stuffer from escaping it. Assumes buf_data_i is the
// buffer byte at buf_addr_o in the same cycle and that the buffer does not
// change while busy_o is high.
module esc_tx_seq
    import esc_tx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              link_up_i,
    output logic [ADDR_W-1:0] buf_addr_o,
    input  logic [7:0]        buf_data_i,
    output logic [7:0]        sym_o,
    output logic              sym_raw_o,
    output logic              sym_valid_o,
    input  logic              sym_ready_i,
    output logic              busy_o
);

    localparam int MIN_BODY_LEN = 3;   // length, netfn, sequence

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] idx_q, idx_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             ann_q, ann_d;
    logic             fire;
    logic             csum_clr;
    logic             csum_add;
    logic [7:0]       csum_sum;
    logic [7:0]       csum_neg;
    seq_state_e       after_frame;

    esc_tx_csum #(.W(8)) u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (csum_clr),
        .add_i  (csum_add),
        .byte_i (buf_data_i),
        .sum_o  (csum_sum),
        .neg_o  (csum_neg)
    );

    assign fire   = sym_valid_o && sym_ready_i;
    assign busy_o = (state_q != ST_IDLE);

    // Map body index to buffer address, swapping positions 1 and 2.
    always_comb begin
        if (idx_q == LEN_W'(1))      buf_addr_o = ADDR_W'(2);
        else if (idx_q == LEN_W'(2)) buf_addr_o = ADDR_W'(1);
        else                         buf_addr_o = idx_q[ADDR_W-1:0];
    end

    // Symbol presented to the stuffer in each state.
    always_comb begin
        sym_o       = 8'h00;
        sym_raw_o   = 1'b0;
        sym_valid_o = 1'b1;
        unique case (state_q)
            ST_BODY:  sym_o = buf_data_i;
            ST_CSUM:  sym_o = csum_neg;
            ST_TERM:  begin sym_o = CODE_EOM; sym_raw_o = 1'b1; end
            ST_VCMD:  sym_o = VER_CMD;
            ST_VNUM:  sym_o = VER_NUM;
            ST_VTERM: begin sym_o = CODE_EOC; sym_raw_o = 1'b1; end
            default:  sym_valid_o = 1'b0;
        endcase
    end

    // Where a finished frame goes: straight into a pending announce, or idle.
    assign after_frame = (ann_q || link_up_i) ? ST_VCMD : ST_IDLE;

    // Next-state, index, length and pending-announce logic.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        len_d    = len_q;
        ann_d    = ann_q || link_up_i;
        csum_clr = 1'b0;
        csum_add = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ann_q || link_up_i) begin
                    state_d = ST_VCMD;
                    ann_d   = 1'b0;
                end else if (start_i) begin
                    len_d    = len_i;
                    idx_d    = LEN_W'(1);
                    csum_clr = 1'b1;
                    state_d  = (len_i < LEN_W'(MIN_BODY_LEN)) ? ST_CSUM : ST_BODY;
                end
            end
            ST_BODY: begin
                if (fire) begin
                    csum_add = 1'b1;
                    if (idx_q == len_q - LEN_W'(1)) state_d = ST_CSUM;
                    else                            idx_d   = idx_q + LEN_W'(1);
                end
            end
            ST_CSUM:  if (fire) state_d = ST_TERM;
            ST_TERM, ST_VTERM: begin
                if (fire) begin
                    state_d = after_frame;
                    if (after_frame == ST_VCMD) ann_d = 1'b0;
                end
            end
            ST_VCMD:  if (fire) state_d = ST_VNUM;
            ST_VNUM:  if (fire) state_d = ST_VTERM;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            ann_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
            ann_q   <= ann_d;
        end
    end

    a_r8_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i || link_up_i || ann_q));

    a_r5_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERM && fire) |=> (state_q == ST_IDLE || state_q == ST_VCMD));

    a_r1_body_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY) |-> (idx_q >= LEN_W'(1) && idx_q < len_q &&
                                  len_q >= LEN_W'(MIN_BODY_LEN)));

    a_r10_pend_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ann_q |-> busy_o);

endmodule

// File: rtl/esc_tx_stuff.sv
// esc_tx_stuff: byte stuffer between the sequencer and the output handshake.
// A reserved symbol not flagged raw costs two output beats: the escape
// prefix, then the symbol with bit 4 set. Assumes the upstream symbol stays
// stable until sym_ready_o accepts it.
module esc_tx_stuff
    import esc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sym_i,
    input  logic       sym_raw_i,
    input  logic       sym_valid_i,
    output logic       sym_ready_o,
    output logic [7:0] tx_data_o,
    output logic       tx_valid_o,
    input  logic       tx_ready_i
);

    logic esc_q;
    logic need_esc;

    assign need_esc = sym_valid_i && !sym_raw_i && is_reserved(sym_i);

    // Output byte: the prefix, then the flipped byte, else the byte itself.
    always_comb begin
        tx_valid_o = sym_valid_i;
        if (esc_q)         tx_data_o = sym_i | ESC_FLIP;
        else if (need_esc) tx_data_o = CODE_ESC;
        else               tx_data_o = sym_i;
        sym_ready_o = tx_ready_i && (esc_q || !need_esc);
    end

    // Track whether the escape prefix has gone out for the current symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)                       esc_q <= 1'b0;
        else if (tx_valid_o && tx_ready_i) esc_q <= esc_q ? 1'b0 : need_esc;
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    a_r3_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(esc_q) |-> $past(tx_data_o == CODE_ESC));

    a_r3_flipped: assert property (@(posedge clk) disable iff (!rst_n)
        esc_q |-> (tx_valid_o && (tx_data_o & ESC_FLIP) != 8'h00));

    a_r5_raw_unescaped: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && sym_raw_i && !esc_q) |-> (tx_data_o == sym_i));

endmodule

// File: rtl/esc_frame_tx.sv
// esc_frame_tx: top of the escaped frame transmitter. The sequencer picks
// symbols from the message buffer or the announce frame; the stuffer adds
// escapes and drives the output handshake. The buffer read is combinational.
module esc_frame_tx #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              link_up_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    input  logic [7:0]        buf_data_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i
);

    logic [7:0] sym;
    logic       sym_raw;
    logic       sym_valid;
    logic       sym_ready;

    esc_tx_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (start_len_i),
        .link_up_i   (link_up_i),
        .buf_addr_o  (buf_addr_o),
        .buf_data_i  (buf_data_i),
        .sym_o       (sym),
        .sym_raw_o   (sym_raw),
        .sym_valid_o (sym_valid),
        .sym_ready_i (sym_ready),
        .busy_o      (busy_o)
    );

    esc_tx_stuff u_stuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_i       (sym),
        .sym_raw_i   (sym_raw),
        .sym_valid_i (sym_valid),
        .sym_ready_o (sym_ready),
        .tx_data_o   (tx_data_o),
        .tx_valid_o  (tx_valid_o),
        .tx_ready_i  (tx_ready_i)
    );

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !tx_valid_o);

endmodule

// File: tb/esc_frame_tx_tb.sv
`timescale 1ns/1ps
module esc_frame_tx_tb;

    localparam int ADDR_W = 6;
    localparam int LEN_W  = 7;
    localparam int NVEC   = 6;
    // Per entry: [0] length, [1..7] buffer positions 1..7.
    localparam logic [7:0] VEC [0:NVEC-1][0:7] = '{
        '{8'd5, 8'h18, 8'h07, 8'h01, 8'h42, 8'h00, 8'h00, 8'h00},
        '{8'd6, 8'hA0, 8'h11, 8'hAA, 8'hA1, 8'h33, 8'h00, 8'h00},
        '{8'd8, 8'h06, 8'hA1, 8'hB0, 8'hA0, 8'h10, 8'hFF, 8'h00},
        '{8'd3, 8'h2C, 8'h3D, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'd3, 8'h20, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'd4, 8'h50, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  start_len_i = '0;
    logic              link_up_i = 1'b0;
    logic              busy_o;
    logic [ADDR_W-1:0] buf_addr_o;
    logic [7:0]        buf_data_i;
    logic [7:0]        tx_data_o;
    logic              tx_valid_o;
    logic              tx_ready_i = 1'b0;

    logic [7:0] mem [0:63];
    logic [7:0] cap [0:255];
    logic [7:0] ex_b [0:255];
    int cap_n = 0, ex_n = 0;
    int checks = 0, fails = 0;
    int rdy_mode = 0, cyc = 0;
    bit mon_on = 1'b0, prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    assign buf_data_i = mem[buf_addr_o];

    esc_frame_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_len_i(start_len_i),
        .link_up_i(link_up_i), .busy_o(busy_o), .buf_addr_o(buf_addr_o),
        .buf_data_i(buf_data_i), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
        .tx_ready_i(tx_ready_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Drive ready by pattern, then sample the handshake off the edge.
    always begin
        @(negedge clk);
        cyc++;
        case (rdy_mode)
            0:       tx_ready_i = 1'b1;
            1:       tx_ready_i = cyc[0];
            default: tx_ready_i = (cyc % 3 == 0);
        endcase
        #1;
        if (mon_on) begin
            if (prev_hold)
                chk(tx_valid_o && tx_data_o == prev_data, "R7", "held byte",
                    int'(tx_data_o), int'(prev_data));
            prev_hold = tx_valid_o && !tx_ready_i;
            prev_data = tx_data_o;
            if (tx_valid_o && tx_ready_i && cap_n < 256) begin
                cap[cap_n] = tx_data_o;
                cap_n++;
            end
        end
    end

    task automatic push(input logic [7:0] b, input bit raw);
        if (!raw && (b == 8'hA0 || b == 8'hA1 || b == 8'hAA)) begin
            ex_b[ex_n] = 8'hAA;
            ex_b[ex_n + 1] = b | 8'h10;
            ex_n += 2;
        end else begin
            ex_b[ex_n] = b;
            ex_n++;
        end
    endtask

    // Expected frame from the requirements (R1..R5, R9).
    task automatic model_frame(input int len);
        logic [7:0] s;
        s = 8'h00;
        if (len >= 3) begin
            push(mem[2], 1'b0); s += mem[2];
            push(mem[1], 1'b0); s += mem[1];
            for (int i = 3; i < len; i++) begin
                push(mem[i], 1'b0);
                s += mem[i];
            end
        end
        push(8'h00 - s, 1'b0);
        push(8'hA0, 1'b1);
    endtask

    task automatic model_announce();
        push(8'hFF, 1'b0);
        push(8'h01, 1'b0);
        push(8'hA1, 1'b1);
    endtask

    task automatic clear_streams();
        cap_n = 0;
        ex_n = 0;
        prev_hold = 1'b0;
    endtask

    task automatic compare(input string req);
        chk(cap_n == ex_n, req, "byte count", cap_n, ex_n);
        for (int i = 0; i < ex_n; i++)
            chk(cap[i] == ex_b[i], req, $sformatf("byte %0d", i), int'(cap[i]), int'(ex_b[i]));
    endtask

    task automatic do_start(input int len);
        @(negedge clk);
        start_i = 1'b1;
        start_len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_link();
        @(negedge clk);
        link_up_i = 1'b1;
        @(negedge clk);
        link_up_i = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        do begin
            @(negedge clk);
            #2;
            t++;
        end while (busy_o && t < 2000);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8ns * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        #2;
        chk(!tx_valid_o && !busy_o, "R11", "outputs in reset", {tx_valid_o, busy_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!tx_valid_o && !busy_o, "R11", "outputs after reset", {tx_valid_o, busy_o}, 0);
        mon_on = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 under three ready patterns (R7).
        for (int v = 0; v < NVEC; v++) begin
            for (int m = 0; m < 3; m++) begin
                for (int i = 0; i < 8; i++) mem[i] = VEC[v][i];
                rdy_mode = m;
                clear_streams();
                model_frame(int'(VEC[v][0]));
                do_start(int'(VEC[v][0]));
                wait_idle();
                compare($sformatf("R1-R5 vec%0d", v));
            end
        end

        // R8: busy timing and a start while busy is ignored.
        rdy_mode = 1;
        for (int i = 0; i < 8; i++) mem[i] = VEC[0][i];
        clear_streams();
        model_frame(5);
        do_start(5);
        #2;
        chk(busy_o, "R8", "busy after start", busy_o, 1);
        do_start(3);
        wait_idle();
        chk(!busy_o, "R8", "busy after terminator", busy_o, 0);
        compare("R8");

        // R9: short lengths send only checksum and terminator.
        rdy_mode = 0;
        for (int L = 0; L < 3; L++) begin
            clear_streams();
            push(8'h00, 1'b0);
            push(8'hA0, 1'b1);
            do_start(L);
            #2;
            chk(busy_o, "R9", "busy for short frame", busy_o, 1);
            wait_idle();
            compare("R9");
        end

        // R6: link-up alone.
        rdy_mode = 2;
        clear_streams();
        model_announce();
        pulse_link();
        wait_idle();
        compare("R6");

        // R10: link-up during a frame follows its terminator.
        for (int i = 0; i < 8; i++) mem[i] = VEC[2][i];
        clear_streams();
        model_frame(8);
        model_announce();
        do_start(8);
        repeat (3) @(negedge clk);
        pulse_link();
        wait_idle();
        compare("R10 mid-frame");

        // R10: link-up and start together; only the announce goes out.
        rdy_mode = 0;
        clear_streams();
        model_announce();
        @(negedge clk);
        start_i = 1'b1;
        start_len_i = LEN_W'(5);
        link_up_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        link_up_i = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        compare("R10 same-cycle");

        summary();
    end

endmodule